// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block drives the reset line of a processor from three causes. The first is power-up, shown by the block's own synchronous reset input. The second is a digital supply-low flag from an external voltage comparator. The third is an active-low manual-reset input, which may come from a push-button or from a watchdog output that is wired to it. Reset stays asserted while any cause is present. It is then stretched for a fixed hold interval, which starts again from the last cause to release.

The manual input passes through a synchronizer and a debounce filter. A level change is accepted only after it has been sampled for `DEB_SAMPLES` consecutive cycles. The supply flag is synchronized but not filtered. The hold interval is given in milliseconds together with the clock rate, and the block converts it to clock ticks (`HOLD_TICKS = CLK_HZ/1000*HOLD_MS`). Two registered outputs give the reset in both polarities.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst` is high, `rst_o`=1 and `rst_n_o`=0. After `rst` falls with both sources idle (`supply_low_i`=0, `man_rst_n_i`=1), reset stays asserted for `HOLD_TICKS` more rising edges and clears on edge number `HOLD_TICKS+1`.
- R2: `supply_low_i`=1 asserts `rst_o` by the `SYNC_STAGES+1`-th rising edge, and `rst_o` stays 1 for as long as the flag stays 1.
- R3: Once `supply_low_i` returns to 0, with no other source active, `rst_o` clears exactly on rising edge number `SYNC_STAGES+HOLD_TICKS+1` after the change.
- R4: Holding `man_rst_n_i` at 0 for at least `DEB_SAMPLES` cycles asserts `rst_o` on edge number `SYNC_STAGES+DEB_SAMPLES+1`. After the input returns to 1, `rst_o` clears `SYNC_STAGES+DEB_SAMPLES+HOLD_TICKS+1` edges later.
- R5: A level of `man_rst_n_i` that lasts fewer than `DEB_SAMPLES` cycles, in either direction, has no effect on the outputs.
- R6: If a source asserts again while the hold interval is running, the interval restarts from its full length when that source releases.
- R7: When both sources are active, the hold interval is timed from whichever of them releases last.
- R8: Outside reset, `rst_n_o` is always the exact complement of `rst_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock at `CLK_HZ` |
| rst | input | 1 | Synchronous active-high power-on reset |
| supply_low_i | input | 1 | Supply-below-threshold flag from the comparator, asynchronous |
| man_rst_n_i | input | 1 | Manual reset request, active low, asynchronous |
| rst_n_o | output | 1 | Processor reset, active low, registered |
| rst_o | output | 1 | Processor reset, active high, registered |

## Verification
The outputs are compared on every cycle against a tick-level model. The model is driven by these patterns:
- A bare power-up shows the load value and the length of the countdown.
- A long supply-low flag shows that reset is held and that the stretch is measured from the flag's release.
- A manual press run through the filter shows the added debounce latency.
- Pulses one and three cycles long, plus a short high glitch during a held press, separate a working filter from a missing one or one with an off-by-one count.
- A source that asserts again partway through the stretch, and overlapping sources that release in turn, show whether the interval reloads and which release it is timed from.

// File: rtl/rsg_pkg.sv
package rsg_pkg;

  typedef struct packed {
    logic supply;
    logic manual;
  } rsg_src_t;

  function automatic int unsigned hold_ticks(input int unsigned clk_hz,
                                             input int unsigned ms);
    return (clk_hz / 1000) * ms;
  endfunction

endpackage

// File: rtl/rsg_sync.sv
module rsg_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] ff;
  logic [STAGES-1:0] nxt;

  generate
    if (STAGES == 1) begin : g_one
      assign nxt = d;
    end else begin : g_many
      assign nxt = {ff[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ff <= {STAGES{RST_VAL}};
    else     ff <= nxt;
  end

  assign q = ff[STAGES-1];
endmodule

// File: rtl/rsg_debounce.sv
module rsg_debounce #(
  parameter int unsigned N        = 4,
  parameter logic        INIT_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  localparam int unsigned CW = $clog2(N + 1);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] run;

  always_ff @(posedge clk) begin
    if (rst) begin
      q   <= INIT_VAL;
      run <= '0;
    end else if (d == q) begin
      run <= '0;
    end else if (run == LAST) begin
      q   <= d;
      run <= '0;
    end else begin
      run <= run + 1'b1;
    end
  end

  // R5
  accept_after_n_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(q) |-> ($past(run) == LAST));
endmodule

// File: rtl/rsg_stretch.sv
module rsg_stretch #(
  parameter int unsigned HOLD = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic src,
  output logic busy
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || src)      cnt <= LOAD;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

  // R6
  reload_full_chk: assert property (@(posedge clk) disable iff (rst)
    src |=> (cnt == LOAD));

  // R3
  count_down_chk: assert property (@(posedge clk) disable iff (rst)
    (!src && busy) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen #(
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned HOLD_MS     = 200,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DEB_SAMPLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_low_i,
  input  logic man_rst_n_i,
  output logic rst_n_o,
  output logic rst_o
);
  import rsg_pkg::*;

  localparam int unsigned HOLD_TICKS = hold_ticks(CLK_HZ, HOLD_MS);

  logic     sup_s;
  logic     man_s;
  logic     man_db;
  rsg_src_t srcs;
  logic     src_any;
  logic     busy;
  logic     want;

  rsg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_sup_sync (
    .clk(clk), .rst(rst), .d(supply_low_i), .q(sup_s));

  rsg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_man_sync (
    .clk(clk), .rst(rst), .d(man_rst_n_i), .q(man_s));

  rsg_debounce #(.N(DEB_SAMPLES), .INIT_VAL(1'b1)) i_man_deb (
    .clk(clk), .rst(rst), .d(man_s), .q(man_db));

  assign srcs.supply = sup_s;
  assign srcs.manual = ~man_db;
  assign src_any     = |srcs;

  rsg_stretch #(.HOLD(HOLD_TICKS)) i_stretch (
    .clk(clk), .rst(rst), .src(src_any), .busy(busy));

  assign want = src_any | busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_o   <= 1'b1;
      rst_n_o <= 1'b0;
    end else begin
      rst_o   <= want;
      rst_n_o <= ~want;
    end
  end

  // R2
  supply_hold_chk: assert property (@(posedge clk) disable iff (rst)
    sup_s |=> rst_o);

  // R4
  manual_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !man_db |=> rst_o);

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (!src_any && !busy) |=> !rst_o);

  // R8
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    rst_o == !rst_n_o);
endmodule

// File: tb/test_supv_reset_gen.sv
module test_supv_reset_gen;
  localparam int unsigned CLK_HZ = 100_000;
  localparam int unsigned HOLD_MS = 1;
  localparam int unsigned SYNC = 2;
  localparam int unsigned DEB = 4;
  localparam int HOLD = (CLK_HZ / 1000) * HOLD_MS;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_low_i = 1'b0;
  logic man_rst_n_i = 1'b1;
  logic rst_n_o, rst_o;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  supv_reset_gen #(.CLK_HZ(CLK_HZ), .HOLD_MS(HOLD_MS), .SYNC_STAGES(SYNC),
                   .DEB_SAMPLES(DEB)) i_supv_reset_gen (
    .clk(clk), .rst(rst), .supply_low_i(supply_low_i),
    .man_rst_n_i(man_rst_n_i), .rst_n_o(rst_n_o), .rst_o(rst_o));

  // behavioural reference: delay queues plus integer timers
  bit sup_q[$];
  bit man_q[$];
  bit man_level = 1'b1;
  int man_run = 0;
  int remain = HOLD;
  bit exp_rst = 1'b1;

  always @(posedge clk) begin
    bit active;
    bit man_seen;
    cycles++;
    if (rst) begin
      sup_q = {}; man_q = {};
      for (int i = 0; i < SYNC; i++) begin sup_q.push_back(1'b0); man_q.push_back(1'b1); end
      man_level = 1'b1; man_run = 0; remain = HOLD; exp_rst = 1'b1;
    end else begin
      active = sup_q[SYNC-1] || !man_level;
      exp_rst = active || (remain > 0);
      if (active) remain = HOLD;
      else if (remain > 0) remain--;
      man_seen = man_q[SYNC-1];
      if (man_seen == man_level) man_run = 0;
      else if (man_run == DEB - 1) begin man_level = man_seen; man_run = 0; end
      else man_run++;
      void'(sup_q.pop_back()); sup_q.push_front(supply_low_i);
      void'(man_q.pop_back()); man_q.push_front(man_rst_n_i);
    end
  end

  task automatic check(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      check(cur_req, rst_o, exp_rst);
      // R8
      check("R8", rst_n_o, ~rst_o);
    end
  end

  task automatic wait_cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles == 150000) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected done");
      finish_run();
    end
  end

  initial begin
    wait_cyc(4);
    // R1 reset state
    check("R1", rst_o, 1'b1);
    check("R1", rst_n_o, 1'b0);
    rst = 1'b0;
    wait_cyc(HOLD - 2);
    check("R1", rst_o, 1'b1);
    wait_cyc(10);
    check("R1", rst_o, 1'b0);

    cur_req = "R2";
    supply_low_i = 1'b1;
    wait_cyc(SYNC + 1);
    check("R2", rst_o, 1'b1);
    wait_cyc(40);
    cur_req = "R3";
    supply_low_i = 1'b0;
    wait_cyc(HOLD - 5);
    check("R3", rst_o, 1'b1);
    wait_cyc(15);
    check("R3", rst_o, 1'b0);

    cur_req = "R4";
    man_rst_n_i = 1'b0;
    wait_cyc(SYNC + DEB + 1);
    check("R4", rst_o, 1'b1);
    wait_cyc(10);
    man_rst_n_i = 1'b1;
    wait_cyc(HOLD);
    check("R4", rst_o, 1'b1);
    wait_cyc(20);
    check("R4", rst_o, 1'b0);

    cur_req = "R5";
    man_rst_n_i = 1'b0; wait_cyc(DEB - 1); man_rst_n_i = 1'b1;
    wait_cyc(20);
    check("R5", rst_o, 1'b0);
    man_rst_n_i = 1'b0; wait_cyc(1); man_rst_n_i = 1'b1;
    wait_cyc(20);
    check("R5", rst_o, 1'b0);
    man_rst_n_i = 1'b0; wait_cyc(30);
    man_rst_n_i = 1'b1; wait_cyc(2); man_rst_n_i = 1'b0;
    wait_cyc(30);
    check("R5", rst_o, 1'b1);
    man_rst_n_i = 1'b1;
    wait_cyc(HOLD + 30);
    check("R5", rst_o, 1'b0);

    cur_req = "R6";
    supply_low_i = 1'b1; wait_cyc(5); supply_low_i = 1'b0;
    wait_cyc(50);
    supply_low_i = 1'b1; wait_cyc(5); supply_low_i = 1'b0;
    wait_cyc(HOLD - 10);
    check("R6", rst_o, 1'b1);
    wait_cyc(30);
    check("R6", rst_o, 1'b0);

    cur_req = "R7";
    man_rst_n_i = 1'b0; wait_cyc(10);
    supply_low_i = 1'b1; wait_cyc(10);
    supply_low_i = 1'b0; wait_cyc(HOLD + 20);
    check("R7", rst_o, 1'b1);
    man_rst_n_i = 1'b1;
    wait_cyc(HOLD - 20);
    check("R7", rst_o, 1'b1);
    wait_cyc(40);
    check("R7", rst_o, 1'b0);

    wait_cyc(5);
    finish_run();
  end
endmodule